// File: doc/BRIEF.md
# Comparator-DAC Successive Approximation Sequencer

This host-side controller turns a remote threshold comparator into an analog-to-digital converter. The comparator sits behind a register-write link. Each write programs a 7-bit threshold code. Each write also returns a status byte. The catch is timing: the comparator bit in that status byte answers the threshold set by the *previous* write, not by the write that carried it. The sequencer therefore issues every trial code twice. The first write sets the threshold. The second write re-sends the same code, and its status byte carries the verdict on that trial.

A conversion begins with a one-cycle `start` pulse. That pulse also latches the channel select and the mode:

- **Full mode** runs a 7-step successive approximation, deciding the most significant bit first.
- **Limit mode** performs a single pass/fail comparison against a supplied code.

When the conversion ends, the block registers the result code, the matching millivolt figure, an under-range flag and a pass flag, and pulses `done`.

Top module: `cmpdac_sar_seq`

## Requirements
- R1: After reset, `busy`, `done`, `wr_valid` and `rsp_ready` are low, and every result output is zero. While idle, no write is issued.
- R2: Write requests use valid/ready. Once `wr_valid` is high, it stays high with `wr_code` unchanged until a cycle with `wr_ready` high. After that acceptance, `rsp_ready` rises, and the response is taken in the first cycle with both `rsp_valid` and `rsp_ready` high. At most one write is outstanding, and `wr_valid` and `rsp_ready` are never high together.
- R3: Full mode decides bits 6 down to 0, one at a time. Each trial code is written twice in a row, so a conversion takes exactly 14 writes, and the first trial is 64. A bit is kept when the verdict taken from the second write of its pair shows the input above the trial threshold. The result is the largest code c in 20..127 whose threshold the input exceeds.
- R4: The verdict is read from status bit 5 for `chan_sel`=0 (external input), bit 6 for 1 (divided backup cell) and bit 7 for 2 (main battery). `chan_sel`=3 behaves as 0. Status bit 4 and bits 3..0 are ignored.
- R5: No write carries a code below 20; trial codes under 20 are raised to 20. If the input exceeds no threshold from 20 upward, the result is code 20 with `res_under`=1 and `res_above`=0.
- R6: Limit mode makes exactly 2 writes of the limit code, raised to 20 if lower. `res_code` is that code, `res_above` is the verdict from the second write, and `res_under` is 0.
- R7: `res_mv` equals `res_code`×10 for channels 0 and 2, and `res_code`×40 for channel 1.
- R8: `done` is high for exactly one cycle per conversion. The result outputs change only in that cycle and hold their values until the next `done`.
- R9: `start`, `chan_sel`, `go_mode` and `limit_code` are sampled only when a start is accepted while idle. A `start` pulse during a conversion has no effect. A `start` pulse in the `done` cycle is accepted and begins a new conversion.
- R10: In full mode, `res_above` is the inverse of `res_under`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle conversion request |
| chan_sel | input | 2 | 0 external, 1 backup cell (÷4), 2 battery, 3 same as 0 |
| go_mode | input | 1 | 1 = single limit check, 0 = full conversion |
| limit_code | input | 7 | Threshold code used for a limit check |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Link accepts the write request |
| wr_code | output | 7 | Threshold code carried by the write |
| rsp_valid | input | 1 | Returned status byte valid |
| rsp_ready | output | 1 | Sequencer waiting for a status byte |
| rsp_status | input | 8 | Status byte; bits 7..5 hold the comparator verdicts |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion strobe |
| res_code | output | 7 | Converted or checked code |
| res_mv | output | 13 | Threshold of `res_code` in millivolts |
| res_under | output | 1 | Input below the lowest usable threshold |
| res_above | output | 1 | Input above the `res_code` threshold |

## Verification
A new `start` can coincide with completion. The bench pulses `start` with fresh channel, mode and input values in the very cycle where `done` is observed high. It then checks that `done` drops after one cycle, that the second conversion makes its full write count, and that its result matches the second set of inputs. A second overlap is a stray `start` that lands while a write handshake is still in flight. The bench pulses `start` mid-conversion with scrambled mode and channel inputs. It then judges the outcome by the write count and result of the original conversion, so any restart or re-latch shows up as a mismatch.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic [1:0] {
    CH_EXT    = 2'd0,
    CH_BACKUP = 2'd1,
    CH_BATT   = 2'd2
  } chan_t;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_NEXT    = 2'd1,
    PH_SET     = 2'd2,
    PH_COLLECT = 2'd3
  } seq_phase_t;

  typedef enum logic [1:0] {
    LK_IDLE = 2'd0,
    LK_REQ  = 2'd1,
    LK_RSP  = 2'd2
  } link_state_t;

  // Unused select value folds onto the external input.
  function automatic chan_t norm_chan(input logic [1:0] sel);
    chan_t c;
    case (sel)
      2'd1:    c = CH_BACKUP;
      2'd2:    c = CH_BATT;
      default: c = CH_EXT;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/sar_link_ctrl.sv
module sar_link_ctrl
  import sar_pkg::*;
#(
  parameter int CODE_W = 7,
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [CODE_W-1:0] issue_code,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [CODE_W-1:0] wr_code,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [STAT_W-1:0] rsp_status,
  output logic              xfer_done,
  output logic [STAT_W-1:0] xfer_status
);

  link_state_t st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= LK_IDLE;
      wr_code     <= '0;
      xfer_done   <= 1'b0;
      xfer_status <= '0;
    end else begin
      xfer_done <= 1'b0;
      case (st)
        LK_IDLE: begin
          if (issue) begin
            wr_code <= issue_code;
            st      <= LK_REQ;
          end
        end
        LK_REQ: begin
          if (wr_ready) st <= LK_RSP;
        end
        LK_RSP: begin
          if (rsp_valid) begin
            xfer_status <= rsp_status;
            xfer_done   <= 1'b1;
            st          <= LK_IDLE;
          end
        end
        default: st <= LK_IDLE;
      endcase
    end
  end

  always_comb begin
    wr_valid  = (st == LK_REQ);
    rsp_ready = (st == LK_RSP);
  end

endmodule

// File: rtl/sar_trial_gen.sv
module sar_trial_gen #(
  parameter int CODE_W   = 7,
  parameter int MIN_CODE = 20,
  localparam int IDX_W   = (CODE_W > 1) ? $clog2(CODE_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              go_mode_i,
  input  logic [CODE_W-1:0] limit_i,
  input  logic              decide,
  input  logic              bit_i,
  output logic [CODE_W-1:0] trial_code,
  output logic [CODE_W-1:0] acc_next,
  output logic              go_o,
  output logic              last_o
);

  localparam logic [IDX_W-1:0]  TOP_IDX = IDX_W'(CODE_W - 1);
  localparam logic [CODE_W-1:0] FLOOR   = CODE_W'(MIN_CODE);

  logic [CODE_W-1:0] acc;
  logic [CODE_W-1:0] limit_q;
  logic [IDX_W-1:0]  idx;
  logic              go_q;
  logic [CODE_W-1:0] probe;
  logic [CODE_W-1:0] raw;

  always_comb begin
    probe    = CODE_W'(1) << idx;
    raw      = go_q ? limit_q : (acc | probe);
    acc_next = (!go_q && bit_i) ? (acc | probe) : acc;
    last_o   = go_q || (idx == '0);
    go_o     = go_q;
  end

  generate
    if (MIN_CODE > 0) begin : g_floor
      always_comb trial_code = (raw < FLOOR) ? FLOOR : raw;
    end else begin : g_nofloor
      always_comb trial_code = raw;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc     <= '0;
      limit_q <= '0;
      idx     <= TOP_IDX;
      go_q    <= 1'b0;
    end else if (init) begin
      acc     <= '0;
      limit_q <= limit_i;
      idx     <= TOP_IDX;
      go_q    <= go_mode_i;
    end else if (decide) begin
      acc <= acc_next;
      if (idx != '0) idx <= idx - 1'b1;
    end
  end

endmodule

// File: rtl/sar_result_fmt.sv
module sar_result_fmt
  import sar_pkg::*;
#(
  parameter int CODE_W     = 7,
  parameter int MIN_CODE   = 20,
  parameter int LSB_MV     = 10,
  parameter int DIV_BACKUP = 4,
  parameter int MV_W       = 13
) (
  input  logic              go_i,
  input  chan_t             chan_i,
  input  logic [CODE_W-1:0] acc_i,
  input  logic [CODE_W-1:0] trial_i,
  input  logic              bit_i,
  output logic [CODE_W-1:0] code_o,
  output logic [MV_W-1:0]   mv_o,
  output logic              under_o,
  output logic              above_o
);

  localparam logic [CODE_W-1:0] FLOOR = CODE_W'(MIN_CODE);
  localparam logic [MV_W-1:0]   STEP_DIRECT = MV_W'(LSB_MV);
  localparam logic [MV_W-1:0]   STEP_DIV    = MV_W'(LSB_MV * DIV_BACKUP);

  logic [MV_W-1:0] step;

  always_comb begin
    if (go_i) begin
      code_o  = trial_i;
      under_o = 1'b0;
      above_o = bit_i;
    end else begin
      under_o = (acc_i < FLOOR);
      code_o  = under_o ? FLOOR : acc_i;
      above_o = !under_o;
    end
    step = (chan_i == CH_BACKUP) ? STEP_DIV : STEP_DIRECT;
    mv_o = MV_W'(code_o) * step;
  end

endmodule

// File: rtl/cmpdac_sar_seq.sv
module cmpdac_sar_seq
  import sar_pkg::*;
#(
  parameter int CODE_W      = 7,
  parameter int MIN_CODE    = 20,
  parameter int LSB_MV      = 10,
  parameter int DIV_BACKUP  = 4,
  parameter int STAT_W      = 8,
  parameter int CH_BIT_BASE = 5,
  localparam int MV_W  = $clog2(((1 << CODE_W) - 1) * LSB_MV * DIV_BACKUP + 1),
  localparam int SEL_W = $clog2(STAT_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        chan_sel,
  input  logic              go_mode,
  input  logic [CODE_W-1:0] limit_code,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [CODE_W-1:0] wr_code,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [STAT_W-1:0] rsp_status,
  output logic              busy,
  output logic              done,
  output logic [CODE_W-1:0] res_code,
  output logic [MV_W-1:0]   res_mv,
  output logic              res_under,
  output logic              res_above
);

  seq_phase_t        st;
  chan_t             ch_q;
  logic              init, issue, decide;
  logic              xfer_done;
  logic [STAT_W-1:0] xfer_status;
  logic [SEL_W-1:0]  bit_pos;
  logic              cmp_bit;
  logic [CODE_W-1:0] trial, acc_nx;
  logic              go_q, last;
  logic [CODE_W-1:0] f_code;
  logic [MV_W-1:0]   f_mv;
  logic              f_under, f_above;

  always_comb begin
    init    = (st == PH_IDLE) && start;
    issue   = (st == PH_NEXT) || ((st == PH_SET) && xfer_done);
    decide  = (st == PH_COLLECT) && xfer_done;
    bit_pos = SEL_W'(CH_BIT_BASE) + SEL_W'(ch_q);
    cmp_bit = xfer_status[bit_pos];
    busy    = (st != PH_IDLE);
  end

  sar_link_ctrl #(.CODE_W(CODE_W), .STAT_W(STAT_W)) link_i (
    .clk(clk), .rst_n(rst_n),
    .issue(issue), .issue_code(trial),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_code(wr_code),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_status(rsp_status),
    .xfer_done(xfer_done), .xfer_status(xfer_status)
  );

  sar_trial_gen #(.CODE_W(CODE_W), .MIN_CODE(MIN_CODE)) trial_i (
    .clk(clk), .rst_n(rst_n),
    .init(init), .go_mode_i(go_mode), .limit_i(limit_code),
    .decide(decide), .bit_i(cmp_bit),
    .trial_code(trial), .acc_next(acc_nx), .go_o(go_q), .last_o(last)
  );

  sar_result_fmt #(
    .CODE_W(CODE_W), .MIN_CODE(MIN_CODE), .LSB_MV(LSB_MV),
    .DIV_BACKUP(DIV_BACKUP), .MV_W(MV_W)
  ) fmt_i (
    .go_i(go_q), .chan_i(ch_q), .acc_i(acc_nx), .trial_i(trial), .bit_i(cmp_bit),
    .code_o(f_code), .mv_o(f_mv), .under_o(f_under), .above_o(f_above)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= PH_IDLE;
      ch_q      <= CH_EXT;
      done      <= 1'b0;
      res_code  <= '0;
      res_mv    <= '0;
      res_under <= 1'b0;
      res_above <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        PH_IDLE: begin
          if (start) begin
            ch_q <= norm_chan(chan_sel);
            st   <= PH_NEXT;
          end
        end
        PH_NEXT: st <= PH_SET;
        PH_SET: begin
          if (xfer_done) st <= PH_COLLECT;
        end
        PH_COLLECT: begin
          if (xfer_done) begin
            if (last) begin
              st        <= PH_IDLE;
              done      <= 1'b1;
              res_code  <= f_code;
              res_mv    <= f_mv;
              res_under <= f_under;
              res_above <= f_above;
            end else begin
              st <= PH_NEXT;
            end
          end
        end
        default: st <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int CODE_W   = 7,
  parameter int MIN_CODE = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [CODE_W-1:0] wr_code,
  input logic              rsp_ready,
  input logic [CODE_W-1:0] res_code,
  input logic              res_under,
  input logic              res_above
);

  localparam logic [CODE_W-1:0] FLOOR = CODE_W'(MIN_CODE);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!wr_valid && !rsp_ready));

  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_code)));

  p_one_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && rsp_ready));

  p_code_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_code >= FLOOR));

  p_under_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_under) |-> (res_code == FLOOR && !res_above));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_res_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(res_code) |-> done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_start_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

endmodule

bind cmpdac_sar_seq sar_seq_chk #(.CODE_W(CODE_W), .MIN_CODE(MIN_CODE)) chk_i (.*);

// File: tb/cmpdac_sar_seq_tb_top.sv
`timescale 1ns/1ps
module cmpdac_sar_seq_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start;
  logic [1:0] chan_sel;
  logic       go_mode;
  logic [6:0] limit_code;
  logic       wr_valid, wr_ready;
  logic [6:0] wr_code;
  logic       rsp_valid, rsp_ready;
  logic [7:0] rsp_status;
  logic       busy, done;
  logic [6:0] res_code;
  logic [12:0] res_mv;
  logic       res_under, res_above;

  int ncmp = 0;
  int nerr = 0;
  int wcount = 0;
  int vin [3];
  int prev_code = 0;
  logic [6:0] wlog [16];

  always #10 clk = ~clk;

  cmpdac_sar_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .chan_sel(chan_sel),
    .go_mode(go_mode), .limit_code(limit_code),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_code(wr_code),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_status(rsp_status),
    .busy(busy), .done(done), .res_code(res_code), .res_mv(res_mv),
    .res_under(res_under), .res_above(res_above)
  );

  function automatic int lsb_of(int ch);
    return (ch == 1) ? 40 : 10;
  endfunction

  // Remote comparator: verdicts answer the previous write's code; code 0 = off.
  function automatic logic [7:0] mk_status(int pc);
    logic [7:0] s;
    s = 8'($urandom) & 8'h1F;
    for (int ch = 0; ch < 3; ch++)
      s[5+ch] = (pc != 0) && (vin[ch] > pc * lsb_of(ch));
    return s;
  endfunction

  function automatic int exp_full(int v, int lsb);
    for (int c = 127; c >= 20; c--)
      if (v > c * lsb) return c;
    return 0;
  endfunction

  task automatic chk(string req, int act, int expv);
    ncmp++;
    if (act != expv) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Link responder with random back-pressure and response delay.
  initial begin : responder
    int dly;
    bit pend, rsp_fire;
    logic [6:0] pcode;
    wr_ready = 1'b0; rsp_valid = 1'b0; rsp_status = '0;
    pend = 0; rsp_fire = 0; dly = 0; pcode = '0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        pend = 0; rsp_fire = 0; rsp_valid = 1'b0; wr_ready = 1'b0; prev_code = 0;
        continue;
      end
      if (rsp_fire) begin
        rsp_valid = 1'b0; prev_code = int'(pcode); pend = 0; rsp_fire = 0;
      end
      if (pend && !rsp_valid) begin
        if (dly == 0) begin
          rsp_valid = 1'b1; rsp_status = mk_status(prev_code);
        end else dly--;
      end
      if (rsp_valid && rsp_ready) rsp_fire = 1;
      wr_ready = ($urandom % 4) != 0;
      if (wr_valid && wr_ready) begin
        pend = 1; pcode = wr_code; dly = $urandom % 3;
        if (wcount < 16) wlog[wcount] = wr_code;
        wcount++;
      end
    end
  end

  int c_ch, c_lim;
  bit c_go;

  task automatic start_conv(int ch, bit go, int lim);
    c_ch = ch; c_go = go; c_lim = lim;
    wcount = 0;
    chan_sel = 2'(ch); go_mode = go; limit_code = 7'(lim); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chan_sel = 2'($urandom); go_mode = 1'($urandom); limit_code = 7'($urandom);
  endtask

  task automatic wait_done(bit poke);
    int cyc = 0;
    while (!done && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      start = (poke && cyc == 6) ? 1'b1 : 1'b0;
    end
    start = 1'b0;
    if (!done) chk("R8 done timeout", 0, 1);
  endtask

  task automatic check_conv();
    int ch, lsb, c, ecode, eunder, eabove;
    ch = (c_ch == 3) ? 0 : c_ch;
    lsb = lsb_of(ch);
    if (c_go) begin
      ecode = (c_lim < 20) ? 20 : c_lim;
      eunder = 0;
      eabove = (vin[ch] > ecode * lsb) ? 1 : 0;
      chk("R6 limit write count", wcount, 2);
      chk("R6 limit code written", int'(wlog[0]), ecode);
      chk("R6 limit code pair", int'(wlog[1]), ecode);
      chk("R6 limit res_code", int'(res_code), ecode);
      chk("R6 limit res_above", int'(res_above), eabove);
      chk("R6 limit res_under", int'(res_under), 0);
    end else begin
      c = exp_full(vin[ch], lsb);
      eunder = (c == 0) ? 1 : 0;
      ecode = eunder ? 20 : c;
      eabove = 1 - eunder;
      chk("R3 full write count", wcount, 14);
      chk("R3 first trial", int'(wlog[0]), 64);
      for (int k = 0; k < 7; k++) begin
        chk("R3 trial pair repeat", int'(wlog[2*k+1]), int'(wlog[2*k]));
        chk("R5 trial floor", (wlog[2*k] >= 7'd20) ? 1 : 0, 1);
      end
      chk("R3 R4 full res_code", int'(res_code), ecode);
      chk("R5 res_under", int'(res_under), eunder);
      chk("R10 res_above", int'(res_above), eabove);
    end
    chk("R7 res_mv", int'(res_mv), ecode * lsb);
  endtask

  task automatic one(int ch, bit go, int lim, bit poke);
    start_conv(ch, go, lim);
    wait_done(poke);
    check_conv();
    @(negedge clk);
    chk("R8 done one cycle", int'(done), 0);
    repeat (3) @(negedge clk);
    chk("R8 result held", int'(res_code), (c_go ? ((c_lim < 20) ? 20 : c_lim)
        : ((exp_full(vin[(c_ch == 3) ? 0 : c_ch], lsb_of((c_ch == 3) ? 0 : c_ch)) == 0) ? 20
        : exp_full(vin[(c_ch == 3) ? 0 : c_ch], lsb_of((c_ch == 3) ? 0 : c_ch)))));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nerr);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start = 1'b0; chan_sel = '0; go_mode = 1'b0; limit_code = '0;
    vin[0] = 0; vin[1] = 0; vin[2] = 0;
    repeat (5) @(negedge clk);
    // R1: reset state, checked while reset is applied and after release
    chk("R1 busy in reset", int'(busy), 0);
    chk("R1 wr_valid in reset", int'(wr_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 busy idle", int'(busy), 0);
    chk("R1 done idle", int'(done), 0);
    chk("R1 rsp_ready idle", int'(rsp_ready), 0);
    chk("R1 res_code zero", int'(res_code), 0);
    chk("R1 res_mv zero", int'(res_mv), 0);
    chk("R1 no writes while idle", wcount, 0);

    // Directed corners (R3 R4 R5 R7)
    vin[0] = 150;  vin[1] = 3000; vin[2] = 900;  one(0, 0, 0, 0);   // under range
    vin[0] = 200;  vin[1] = 100;  vin[2] = 1400; one(0, 0, 0, 0);   // exactly at floor: under
    vin[0] = 201;  vin[1] = 5000; vin[2] = 50;   one(0, 0, 0, 0);   // just above floor
    vin[0] = 1271; vin[1] = 10;   vin[2] = 10;   one(0, 0, 0, 0);   // top code
    vin[0] = 1270; vin[1] = 5081; vin[2] = 700;  one(1, 0, 0, 0);   // backup, /4 scale top
    vin[0] = 900;  vin[1] = 1234; vin[2] = 1270; one(2, 0, 0, 0);   // battery 126
    vin[0] = 555;  vin[1] = 4000; vin[2] = 300;  one(3, 0, 0, 0);   // R4 select 3 = ext
    // R6 limit checks, including a limit below the floor
    vin[0] = 800;  vin[1] = 2000; vin[2] = 900;  one(0, 1, 79, 0);
    vin[0] = 800;  vin[1] = 2000; vin[2] = 900;  one(0, 1, 80, 0);
    one(1, 1, 49, 0);
    one(2, 1, 5, 0);
    vin[2] = 150; one(2, 1, 0, 0);
    // R9: stray start mid-conversion is ignored
    vin[0] = 640; vin[1] = 3330; vin[2] = 1111; one(2, 0, 0, 1);
    one(1, 1, 90, 1);

    // R9: start in the done cycle begins the next conversion
    vin[0] = 432; vin[1] = 2500; vin[2] = 1000;
    start_conv(0, 0, 0);
    wait_done(0);
    check_conv();
    vin[0] = 987; vin[1] = 4321; vin[2] = 333;
    start_conv(1, 0, 0);
    chk("R8 R9 done one cycle with restart", int'(done), 0);
    chk("R9 restart accepted", int'(busy), 1);
    wait_done(0);
    check_conv();
    @(negedge clk);

    // Constrained random mix
    for (int n = 0; n < 30; n++) begin
      vin[0] = $urandom % 1400;
      vin[1] = $urandom % 5400;
      vin[2] = $urandom % 1400;
      one(int'($urandom % 4), 1'($urandom), int'($urandom % 128), 1'(($urandom % 4) == 0));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nerr);
    $finish;
  end

endmodule